// File: doc/BRIEF.md
# Shadowed Ping-Pong Frame Address Selector

This block keeps, for each of eight capture contexts, two destination base addresses for incoming pixel frames, called ping and pong, and decides which of the two each new frame is written to. Software programs both addresses through a 32-bit word-wide register port. Each write lands in a shadow copy, and the copy only takes effect when that context's frame-start strobe arrives. This means software can reprogram buffers at any time during a frame without disturbing the frame already in progress.

When a frame-start strobe arrives, the shadow pair becomes the active pair. If the two addresses differ, the context alternates between them from frame to frame. If they are equal, every frame goes to the same place. There is no separate enable for the alternation. Addresses are 32-byte aligned, so the lowest five address bits are always zero.

Top module: `pingpong_addr_sel`

## Requirements
- R1: Context k (0..7) has its ping register at byte address 0x7C + 32*k and its pong register at 0x80 + 32*k. A write to any other address changes nothing, and a read of any other address returns zero.
- R2: A write is stored only when all four byte enables are 1 (reg_be = 4'hF). A write with any other byte-enable pattern leaves the shadow contents unchanged.
- R3: Bits 4:0 of written data are discarded. Bits 4:0 of reg_rdata and of every dest_addr slice are always 0.
- R4: After synchronous reset, every shadow and active address is zero, every dest_addr slice is 0, buf_sel is 0 and reg_rdata is 0.
- R5: A read returns the shadow value (the most recently written one), not the active one. reg_rdata shows the value for the address presented one clock edge earlier.
- R6: A context's dest_addr and buf_sel change only at a clock edge where its frame_start bit is high. A shadow write becomes visible on dest_addr only after the next such edge. The new value appears right after that edge.
- R7: The first frame start of a context after reset selects ping (buf_sel bit = 0, meaning ping; 1 means pong).
- R8: On each later frame start, if the shadow ping and pong being loaded differ, the selection toggles from its previous value.
- R9: On a frame start where the shadow ping and pong are equal, buf_sel becomes 0, and dest_addr equals that common address.
- R10: A register write in the same cycle as that context's frame start updates only the shadow. The active address loaded at that edge is the shadow value from before the write.
- R11: A frame start or a write on one context leaves every other context's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for write and read |
| reg_be | input | 4 | Byte enables; only 4'hF writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data (shadow value) |
| frame_start | input | 8 | Per-context frame-start strobe |
| dest_addr | output | 256 | Active destination address, context k at bits 32k+31:32k |
| buf_sel | output | 8 | Per-context selection, 0 = ping, 1 = pong |

## Verification
Each result has a fixed latency. A frame start sampled at one edge changes dest_addr and buf_sel right after that edge, and an address presented at one edge produces reg_rdata right after that edge. Register writes reach the ports only through a read one cycle later, or through dest_addr after a later frame start. The bench drives inputs on the falling edge. It advances its reference model on the rising edge in the order read, then frame load, then write, and it compares every output on the next falling edge, so every expected value is taken exactly one edge after its stimulus.

// File: rtl/ppsel_pkg.sv
package ppsel_pkg;
    parameter int unsigned BUS_W   = 32;
    parameter int unsigned ALIGN_W = 5;
    parameter int unsigned FIELD_W = BUS_W - ALIGN_W;
    parameter int unsigned REG_AW  = 12;
    parameter int unsigned BE_W    = BUS_W / 8;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        field_t ping;
        field_t pong;
    } pair_t;

    typedef enum logic {
        SEL_PING = 1'b0,
        SEL_PONG = 1'b1
    } bufsel_e;

    function automatic logic [BUS_W-1:0] to_bus(input field_t f);
        return {f, {ALIGN_W{1'b0}}};
    endfunction

    function automatic field_t from_bus(input logic [BUS_W-1:0] w);
        return w[BUS_W-1:ALIGN_W];
    endfunction
endpackage

// File: rtl/ppsel_decode.sv
module ppsel_decode
    import ppsel_pkg::*;
#(
    parameter int unsigned N_CTX     = 8,
    parameter int unsigned STRIDE    = 32,
    parameter int unsigned PING_BASE = 'h7C,
    parameter int unsigned PONG_BASE = 'h80
) (
    input  logic [REG_AW-1:0] addr,
    output logic [N_CTX-1:0]  ping_hit,
    output logic [N_CTX-1:0]  pong_hit
);
    for (genvar g = 0; g < N_CTX; g++) begin : g_dec
        localparam int unsigned PING_A = PING_BASE + g * STRIDE;
        localparam int unsigned PONG_A = PONG_BASE + g * STRIDE;
        assign ping_hit[g] = (addr == REG_AW'(PING_A));
        assign pong_hit[g] = (addr == REG_AW'(PONG_A));
    end
endmodule

// File: rtl/ppsel_ctx.sv
module ppsel_ctx
    import ppsel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_ping,
    input  logic   wr_pong,
    input  field_t wfield,
    input  logic   frame_start,
    output pair_t  shadow,
    output field_t dest,
    output logic   sel_pong
);
    pair_t   active_q;
    pair_t   shadow_q;
    bufsel_e sel_q;
    logic    started_q;
    bufsel_e sel_next;

    always_comb begin
        if (!started_q) begin
            sel_next = SEL_PING;
        end else if (shadow_q.ping != shadow_q.pong) begin
            sel_next = (sel_q == SEL_PING) ? SEL_PONG : SEL_PING;
        end else begin
            sel_next = SEL_PING;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q  <= '0;
            active_q  <= '0;
            sel_q     <= SEL_PING;
            started_q <= 1'b0;
        end else begin
            if (frame_start) begin
                active_q  <= shadow_q;
                sel_q     <= sel_next;
                started_q <= 1'b1;
            end
            if (wr_ping) shadow_q.ping <= wfield;
            if (wr_pong) shadow_q.pong <= wfield;
        end
    end

    assign shadow   = shadow_q;
    assign dest     = (sel_q == SEL_PONG) ? active_q.pong : active_q.ping;
    assign sel_pong = (sel_q == SEL_PONG);
endmodule

// File: rtl/ppsel_rdmux.sv
module ppsel_rdmux
    import ppsel_pkg::*;
#(
    parameter int unsigned N_CTX = 8
) (
    input  logic [N_CTX-1:0] ping_hit,
    input  logic [N_CTX-1:0] pong_hit,
    input  pair_t            shadow [N_CTX],
    output logic [BUS_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        for (int k = 0; k < N_CTX; k++) begin
            if (ping_hit[k]) rdata = rdata | to_bus(shadow[k].ping);
            if (pong_hit[k]) rdata = rdata | to_bus(shadow[k].pong);
        end
    end
endmodule

// File: rtl/pingpong_addr_sel.sv
module pingpong_addr_sel
    import ppsel_pkg::*;
#(
    parameter int unsigned N_CTX     = 8,
    parameter int unsigned STRIDE    = 32,
    parameter int unsigned PING_BASE = 'h7C,
    parameter int unsigned PONG_BASE = 'h80
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [BE_W-1:0]        reg_be,
    input  logic [BUS_W-1:0]       reg_wdata,
    output logic [BUS_W-1:0]       reg_rdata,
    input  logic [N_CTX-1:0]       frame_start,
    output logic [N_CTX*BUS_W-1:0] dest_addr,
    output logic [N_CTX-1:0]       buf_sel
);
    localparam int unsigned PAIR_W = 2 * FIELD_W;

    logic [N_CTX-1:0]        ping_hit;
    logic [N_CTX-1:0]        pong_hit;
    logic                    wr_ok;
    pair_t                   shadow [N_CTX];
    field_t                  dest_f [N_CTX];
    logic [BUS_W-1:0]        rd_mux;
    logic [BUS_W-1:0]        rdata_q;
    logic [N_CTX*PAIR_W-1:0] shadow_flat;

    assign wr_ok = reg_wr && (reg_be == {BE_W{1'b1}});

    ppsel_decode #(
        .N_CTX    (N_CTX),
        .STRIDE   (STRIDE),
        .PING_BASE(PING_BASE),
        .PONG_BASE(PONG_BASE)
    ) u_dec (
        .addr    (reg_addr),
        .ping_hit(ping_hit),
        .pong_hit(pong_hit)
    );

    for (genvar g = 0; g < N_CTX; g++) begin : g_ctx
        ppsel_ctx u_ctx (
            .clk        (clk),
            .rst        (rst),
            .wr_ping    (wr_ok && ping_hit[g]),
            .wr_pong    (wr_ok && pong_hit[g]),
            .wfield     (from_bus(reg_wdata)),
            .frame_start(frame_start[g]),
            .shadow     (shadow[g]),
            .dest       (dest_f[g]),
            .sel_pong   (buf_sel[g])
        );
        assign dest_addr[g*BUS_W +: BUS_W]    = to_bus(dest_f[g]);
        assign shadow_flat[g*PAIR_W +: PAIR_W] = shadow[g];
    end

    ppsel_rdmux #(
        .N_CTX(N_CTX)
    ) u_rd (
        .ping_hit(ping_hit),
        .pong_hit(pong_hit),
        .shadow  (shadow),
        .rdata   (rd_mux)
    );

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;
endmodule

// File: rtl/ppsel_checker.sv
module ppsel_checker
    import ppsel_pkg::*;
#(
    parameter int unsigned N_CTX = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       reg_wr,
    input logic [BE_W-1:0]            reg_be,
    input logic [N_CTX-1:0]           frame_start,
    input logic [N_CTX*BUS_W-1:0]     dest_addr,
    input logic [N_CTX-1:0]           buf_sel,
    input logic [BUS_W-1:0]           reg_rdata,
    input logic [N_CTX*2*FIELD_W-1:0] shadow_flat
);
    localparam int unsigned PAIR_W = 2 * FIELD_W;

    p_partial_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_be != {BE_W{1'b1}}) |=> $stable(shadow_flat));

    p_rdata_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[ALIGN_W-1:0] == '0);

    p_reset_clear_r4: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dest_addr == '0 && buf_sel == '0 && reg_rdata == '0));

    for (genvar g = 0; g < N_CTX; g++) begin : g_chk
        p_dest_aligned_r3: assert property (@(posedge clk) disable iff (rst)
            dest_addr[g*BUS_W +: ALIGN_W] == '0);

        p_hold_no_frame_r6: assert property (@(posedge clk) disable iff (rst)
            !frame_start[g] |=> ($stable(dest_addr[g*BUS_W +: BUS_W]) && $stable(buf_sel[g])));

        p_equal_ping_r9: assert property (@(posedge clk) disable iff (rst)
            (frame_start[g] &&
             shadow_flat[g*PAIR_W + FIELD_W +: FIELD_W] == shadow_flat[g*PAIR_W +: FIELD_W])
            |=> !buf_sel[g]);
    end
endmodule

bind pingpong_addr_sel ppsel_checker #(.N_CTX(N_CTX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_be     (reg_be),
    .frame_start(frame_start),
    .dest_addr  (dest_addr),
    .buf_sel    (buf_sel),
    .reg_rdata  (reg_rdata),
    .shadow_flat(shadow_flat)
);

// File: tb/pingpong_addr_sel_test.sv
`timescale 1ns/1ps
module pingpong_addr_sel_test;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [3:0]    reg_be = 4'hF;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  frame_start = '0;
    logic [N*32-1:0] dest_addr;
    logic [N-1:0]  buf_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pingpong_addr_sel uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_start(frame_start), .dest_addr(dest_addr), .buf_sel(buf_sel)
    );

    // behavioural reference model
    logic [31:0] m_sping [N];
    logic [31:0] m_spong [N];
    logic [31:0] m_aping [N];
    logic [31:0] m_apong [N];
    bit          m_started [N];
    bit          m_sel [N];
    logic [31:0] m_rdata;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) begin
                m_sping[k] = 0; m_spong[k] = 0; m_aping[k] = 0; m_apong[k] = 0;
                m_started[k] = 0; m_sel[k] = 0;
            end
            m_rdata = 0;
        end else begin
            m_rdata = 0;
            for (int k = 0; k < N; k++) begin
                if (reg_addr == 12'(32'h7C + k*32)) m_rdata = m_sping[k];
                if (reg_addr == 12'(32'h80 + k*32)) m_rdata = m_spong[k];
            end
            for (int k = 0; k < N; k++) begin
                if (frame_start[k]) begin
                    m_aping[k] = m_sping[k];
                    m_apong[k] = m_spong[k];
                    if (!m_started[k]) m_sel[k] = 0;
                    else if (m_sping[k] != m_spong[k]) m_sel[k] = !m_sel[k];
                    else m_sel[k] = 0;
                    m_started[k] = 1;
                end
            end
            if (reg_wr && reg_be == 4'hF) begin
                for (int k = 0; k < N; k++) begin
                    if (reg_addr == 12'(32'h7C + k*32)) m_sping[k] = reg_wdata & 32'hFFFF_FFE0;
                    if (reg_addr == 12'(32'h80 + k*32)) m_spong[k] = reg_wdata & 32'hFFFF_FFE0;
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int k = 0; k < N; k++) begin
                check("R6 dest", dest_addr[k*32 +: 32], m_sel[k] ? m_apong[k] : m_aping[k]);
                check("R8 buf_sel", {31'd0, buf_sel[k]}, {31'd0, m_sel[k]});
            end
            check("R5 rdata", reg_rdata, m_rdata);
        end
    end

    function automatic logic [11:0] ping_a(input int k); return 12'(32'h7C + k*32); endfunction
    function automatic logic [11:0] pong_a(input int k); return 12'(32'h80 + k*32); endfunction
    function automatic logic [31:0] dst(input int k); return dest_addr[k*32 +: 32]; endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'hF;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic frame(input logic [N-1:0] m);
        @(negedge clk);
        frame_start = m;
        @(negedge clk);
        frame_start = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: reset state
        check("R4 dest", dest_addr[31:0], 32'h0);
        check("R4 buf_sel", {24'd0, buf_sel}, 32'h0);
        check("R4 rdata", reg_rdata, 32'h0);

        // R3 / R5: low bits dropped, read returns shadow
        wr(ping_a(0), 32'h1000_0013, 4'hF);
        rd(ping_a(0), v);
        check("R3 low bits", v, 32'h1000_0000);
        check("R6 no frame yet", dst(0), 32'h0);

        // R2: partial write ignored
        wr(pong_a(0), 32'h2000_0000, 4'hF);
        wr(ping_a(0), 32'hDEAD_0000, 4'h3);
        rd(ping_a(0), v);
        check("R2 partial", v, 32'h1000_0000);

        // R7 / R8: first frame ping, then alternate
        frame(8'h01);
        check("R7 first ping", dst(0), 32'h1000_0000);
        check("R7 sel", {31'd0, buf_sel[0]}, 32'h0);
        frame(8'h01);
        check("R8 toggle pong", dst(0), 32'h2000_0000);
        frame(8'h01);
        check("R8 toggle ping", dst(0), 32'h1000_0000);
        d0 = dst(0);

        // R5: read shows shadow, not active
        wr(ping_a(0), 32'h1100_0000, 4'hF);
        rd(ping_a(0), v);
        check("R5 shadow read", v, 32'h1100_0000);
        check("R6 active held", dst(0), d0);

        // R9 / R11: equal addresses on context 3
        wr(ping_a(3), 32'h3000_0040, 4'hF);
        wr(pong_a(3), 32'h3000_0040, 4'hF);
        frame(8'h08);
        frame(8'h08);
        check("R9 equal dest", dst(3), 32'h3000_0040);
        check("R9 equal sel", {31'd0, buf_sel[3]}, 32'h0);
        check("R11 ctx0 untouched", dst(0), d0);

        // R1: unmapped address
        wr(12'h084, 32'hFFFF_FFE0, 4'hF);
        rd(12'h084, v);
        check("R1 unmapped read", v, 32'h0);
        wr(pong_a(7), 32'h7700_0000, 4'hF);
        rd(pong_a(7), v);
        check("R1 ctx7 pong", v, 32'h7700_0000);
        rd(ping_a(7), v);
        check("R1 ctx7 ping", v, 32'h0);

        // R10: write coinciding with frame start
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ping_a(5); reg_wdata = 32'h5000_0000; frame_start = 8'h20;
        @(negedge clk);
        reg_wr = 1'b0; frame_start = '0;
        check("R10 old shadow loaded", dst(5), 32'h0);
        frame(8'h20);
        check("R10 next frame pong", dst(5), 32'h0);
        check("R10 sel", {31'd0, buf_sel[5]}, 32'h1);

        // mixed traffic, checked cycle by cycle against the model
        for (int i = 0; i < 4000; i++) begin
            int c;
            @(negedge clk);
            c = int'($urandom % 8);
            reg_wr = ($urandom % 3) == 0;
            reg_addr = (($urandom % 2) != 0) ? ping_a(c) : pong_a(c);
            if (($urandom % 10) == 0) reg_addr = 12'($urandom);
            reg_be = (($urandom % 5) == 0) ? 4'($urandom) : 4'hF;
            reg_wdata = (($urandom % 4) == 0) ? 32'h4000_0000 : $urandom;
            frame_start = (($urandom % 3) == 0) ? 8'($urandom) : 8'h00;
        end
        @(negedge clk);
        reg_wr = 1'b0; frame_start = '0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule